// File: doc/BRIEF.md
# Infrared Symbol Timing Capture Receiver

This block is the front end of a remote-control receiver. A demodulated infrared or UHF envelope arrives on one pin. The block resynchronises it and can invert it. It then filters out short glitches and samples the result on a tick derived from the system clock. For every symbol it measures two values in ticks. The first is how long the carrier was present (the mark). The second is the full symbol period, counted from the start of one mark to the start of the next. Software derives the space as period minus mark.

Each mark/period pair enters a small capture FIFO. Software drains it through a word-addressed register port, and an interrupt line reports events. When no new mark starts within a programmable number of ticks, the pending symbol is stored with period 0xFFFF. That value marks the last symbol of a train.

Top module: `ir_sym_capture`

Register map (word address on `reg_addr_i`): 0 control (bit 0 capture enable, bit 1 input invert), 1 tick divisor, 2 end-of-train limit, 3 minimum glitch width, 4 interrupt enable, 5 interrupt status, 6 interrupt clear (write only), 7 receive status, 8 popped mark, 9 period/pop. The interrupt registers share one layout: bit 0 entry stored, bit 1 end-of-train entry stored, bit 2 overrun, bit 3 FIFO full. Unlisted addresses read as 0.

## Requirements
- R1: With the input high for H ticks and then low for L ticks before the next rise, the stored entry has mark = H and period = H + L. The first rise after enable starts timing and stores nothing.
- R2: One tick occurs every N system clocks, where N is the divisor at address 1 (0 acts as 1; reset value 1).
- R3: If no rise occurs within the limit at address 2 (in ticks from the last rise, reset value 0x5000), the pending mark is stored with period 0xFFFF and status bit 1 is set.
- R4: With control bit 1 set, the input pin is inverted before any other processing.
- R5: A level on the input that lasts fewer ticks than the width at address 3 is ignored; a level lasting at least that width is kept, with its duration preserved.
- R6: Status bits set on their events and stay set until a 1 is written to the same bit of the clear register (bit 3 also stays set while the FIFO is full). `irq_o` is high exactly when some status bit and its enable bit are both set.
- R7: Receive status holds the FIFO fill count in bits 15:8 and the overrun flag in bit 2; every other bit is 0.
- R8: Reading address 9 returns the oldest entry's period and pops it. Address 8 then returns that entry's mark. The FIFO holds 8 entries in arrival order. Reading address 9 while the FIFO is empty returns 0 and changes nothing.
- R9: A symbol that completes while the FIFO is full is dropped, the stored entries are unchanged, and status bit 2 is set.
- R10: Mark and period counts saturate at 0xFFFF.
- R11: Clearing control bit 0 flushes the FIFO, clears all status bits and resets the symbol timing, so a later enable starts a fresh train.
- R12: After reset, control, interrupt enable, interrupt status and receive status read 0, the divisor reads 1 and the limit reads 0x5000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Demodulated receiver input, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on address 9) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
Plain pulse-width trains are captured with two different divisors. A wrong tick rate or an off-by-one in the mark or period counter shows up directly in the values read back, and the trailing timeout entry shows that the end-of-train path works. The same train is sent with the pin inverted to confirm that inversion comes before edge detection. Trains with short high pulses inside spaces and short low dips inside marks show whether the glitch width is honoured without distorting the durations of real levels. A burst longer than the FIFO is used to tell dropping apart from overwriting. A disable in the middle of a symbol shows whether timing state is really reset. A very long mark shows counter saturation.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned IRQ_W  = 4;
  localparam int unsigned LVL_W  = 8;

  typedef logic [CNT_W-1:0] tick_cnt_t;

  typedef struct packed {
    tick_cnt_t mark;
    tick_cnt_t period;
  } sym_entry_t;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIV    = 4'd1;
  localparam logic [ADDR_W-1:0] A_MAXP   = 4'd2;
  localparam logic [ADDR_W-1:0] A_GLITCH = 4'd3;
  localparam logic [ADDR_W-1:0] A_IEN    = 4'd4;
  localparam logic [ADDR_W-1:0] A_ISTAT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_ICLR   = 4'd6;
  localparam logic [ADDR_W-1:0] A_RXSTAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_MARK   = 4'd8;
  localparam logic [ADDR_W-1:0] A_PERIOD = 4'd9;

  localparam int unsigned IRQ_RX   = 0;
  localparam int unsigned IRQ_LAST = 1;
  localparam int unsigned IRQ_OVR  = 2;
  localparam int unsigned IRQ_FULL = 3;

  localparam tick_cnt_t MAXP_RST = 16'h5000;

  function automatic tick_cnt_t sat_inc(tick_cnt_t v);
    return (v == '1) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;
  logic             wrap;

  assign last   = (div_i == '0) ? '0 : div_i - 1'b1;
  assign wrap   = (cnt_q >= last);
  assign tick_o = en_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i || wrap)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ir_glitch_filter.sv
module ir_glitch_filter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         raw_i,
  input  logic         invert_i,
  input  logic [W-1:0] min_w_i,
  output logic         level_o
);
  logic [1:0]   sync_q;
  logic         lvl_q;
  logic [W-1:0] run_q;
  logic         smp;
  logic         hit;

  assign smp     = sync_q[1] ^ invert_i;
  assign hit     = ({1'b0, run_q} + 1'b1) >= {1'b0, min_w_i};
  assign level_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (!en_i) begin
        lvl_q <= 1'b0;
        run_q <= '0;
      end else if (tick_i) begin
        if (smp == lvl_q) begin
          run_q <= '0;
        end else if (hit) begin
          lvl_q <= smp;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ir_sym_meter.sv
module ir_sym_meter
  import ir_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       level_i,
  input  tick_cnt_t  max_per_i,
  output logic       push_o,
  output sym_entry_t entry_o,
  output logic       last_o
);
  typedef enum logic [1:0] {S_IDLE, S_MARK, S_SPACE} meter_st_e;

  meter_st_e st_q;
  tick_cnt_t mark_q, per_q;
  logic      lvl_q;
  logic      rise, tmo;

  assign rise = tick_i & level_i & ~lvl_q;
  assign tmo  = tick_i & ~rise & (st_q == S_SPACE) & (per_q >= max_per_i);

  assign push_o         = (rise & (st_q == S_SPACE)) | tmo;
  assign last_o         = tmo;
  assign entry_o.mark   = mark_q;
  assign entry_o.period = tmo ? '1 : per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      mark_q <= '0;
      per_q  <= '0;
      lvl_q  <= 1'b0;
    end else if (!en_i) begin
      st_q   <= S_IDLE;
      mark_q <= '0;
      per_q  <= '0;
      lvl_q  <= 1'b0;
    end else if (tick_i) begin
      lvl_q <= level_i;
      if (rise) begin
        st_q   <= S_MARK;
        mark_q <= tick_cnt_t'(1);
        per_q  <= tick_cnt_t'(1);
      end else begin
        unique case (st_q)
          S_MARK: begin
            per_q <= sat_inc(per_q);
            if (level_i) mark_q <= sat_inc(mark_q);
            else         st_q   <= S_SPACE;
          end
          S_SPACE: begin
            if (tmo) st_q  <= S_IDLE;
            else     per_q <= sat_inc(per_q);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ir_cap_fifo.sv
module ir_cap_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          overflow_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o     = (cnt_q == CW'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign do_push    = push_i & ~full_o;
  assign do_pop     = pop_i & ~empty_o;
  assign overflow_o = push_i & full_o;
  assign head_o     = mem_q[rp_q];
  assign count_o    = cnt_q;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/ir_sym_capture.sv
module ir_sym_capture
  import ir_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_FW  = $clog2(DEPTH + 1);
  localparam int unsigned ENTRY_W = 2 * CNT_W;
  localparam int unsigned LVL_LO  = CNT_W - LVL_W;

  logic             rx_en_q, inv_q;
  tick_cnt_t        div_q, maxp_q, glitch_q, mark_rd_q;
  logic [IRQ_W-1:0] ien_q, irq_stat_q, stat_set, stat_clr;

  logic             tick, level;
  logic             sym_push, sym_last;
  sym_entry_t       sym_entry, head;
  tick_cnt_t        sym_mark, sym_per;
  logic [ENTRY_W-1:0] head_raw;
  logic [CNT_FW-1:0]  fifo_count;
  logic             fifo_full, fifo_empty, fifo_ovf, fifo_pop, fifo_push_ok;

  assign sym_mark = sym_entry.mark;
  assign sym_per  = sym_entry.period;
  assign head     = sym_entry_t'(head_raw);

  ir_tick_gen #(.DIV_W(CNT_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rx_en_q),
    .div_i (div_q),
    .tick_o(tick)
  );

  ir_glitch_filter #(.W(CNT_W)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_en_q),
    .tick_i  (tick),
    .raw_i   (rx_i),
    .invert_i(inv_q),
    .min_w_i (glitch_q),
    .level_o (level)
  );

  ir_sym_meter u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en_q),
    .tick_i   (tick),
    .level_i  (level),
    .max_per_i(maxp_q),
    .push_o   (sym_push),
    .entry_o  (sym_entry),
    .last_o   (sym_last)
  );

  assign fifo_pop     = reg_re_i & (reg_addr_i == A_PERIOD) & ~fifo_empty;
  assign fifo_push_ok = sym_push & ~fifo_full;

  ir_cap_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (~rx_en_q),
    .push_i    (sym_push),
    .data_i    (sym_entry),
    .pop_i     (fifo_pop),
    .head_o    (head_raw),
    .count_o   (fifo_count),
    .full_o    (fifo_full),
    .empty_o   (fifo_empty),
    .overflow_o(fifo_ovf)
  );

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q  <= 1'b0;
      inv_q    <= 1'b0;
      div_q    <= tick_cnt_t'(1);
      maxp_q   <= MAXP_RST;
      glitch_q <= '0;
      ien_q    <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        A_CTRL:   {inv_q, rx_en_q} <= reg_wdata_i[1:0];
        A_DIV:    div_q    <= reg_wdata_i;
        A_MAXP:   maxp_q   <= reg_wdata_i;
        A_GLITCH: glitch_q <= reg_wdata_i;
        A_IEN:    ien_q    <= reg_wdata_i[IRQ_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    stat_set           = '0;
    stat_set[IRQ_RX]   = fifo_push_ok;
    stat_set[IRQ_LAST] = fifo_push_ok & sym_last;
    stat_set[IRQ_OVR]  = fifo_ovf;
    stat_set[IRQ_FULL] = fifo_full;
    stat_clr = (reg_we_i && reg_addr_i == A_ICLR) ? reg_wdata_i[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_stat_q <= '0;
    else if (!rx_en_q) irq_stat_q <= '0;
    else               irq_stat_q <= (irq_stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mark_rd_q <= '0;
    else if (fifo_pop) mark_rd_q <= head.mark;
  end

  assign irq_o = |(irq_stat_q & ien_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL:   reg_rdata_o = {{(CNT_W-2){1'b0}}, inv_q, rx_en_q};
      A_DIV:    reg_rdata_o = div_q;
      A_MAXP:   reg_rdata_o = maxp_q;
      A_GLITCH: reg_rdata_o = glitch_q;
      A_IEN:    reg_rdata_o = {{(CNT_W-IRQ_W){1'b0}}, ien_q};
      A_ISTAT:  reg_rdata_o = {{(CNT_W-IRQ_W){1'b0}}, irq_stat_q};
      A_RXSTAT: begin
        reg_rdata_o[CNT_W-1:LVL_LO] = {{(LVL_W-CNT_FW){1'b0}}, fifo_count};
        reg_rdata_o[IRQ_OVR]        = irq_stat_q[IRQ_OVR];
      end
      A_MARK:   reg_rdata_o = mark_rd_q;
      A_PERIOD: reg_rdata_o = fifo_empty ? '0 : head.period;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ir_sym_capture_chk.sv
module ir_sym_capture_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             push_i,
  input logic             full_i,
  input logic             pop_i,
  input logic [CW-1:0]    count_i,
  input logic [3:0]       stat_i,
  input logic [CNT_W-1:0] mark_i,
  input logic [CNT_W-1:0] per_i
);
  assert_mark_le_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (mark_i <= per_i));

  assert_fill_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));

  assert_pop_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pop_i && !push_i) |=> (count_i == $past(count_i) - 1'b1));

  assert_overrun_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && push_i && full_i && !pop_i) |=> ($stable(count_i) && stat_i[2]));

  assert_disable_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (count_i == '0 && stat_i == '0));
endmodule

bind ir_sym_capture ir_sym_capture_chk #(
  .DEPTH(DEPTH),
  .CW   (CNT_FW),
  .CNT_W(CNT_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (rx_en_q),
  .push_i (sym_push),
  .full_i (fifo_full),
  .pop_i  (fifo_pop),
  .count_i(fifo_count),
  .stat_i (irq_stat_q),
  .mark_i (sym_mark),
  .per_i  (sym_per)
);

// File: tb/ir_sym_capture_bench.sv
module ir_sym_capture_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_re_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  int div_b = 1;
  logic inv_b = 1'b0;
  bit mon_on = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk_i = ~clk_i;

  ir_sym_capture u_ir_sym_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_i),
    .reg_we_i   (reg_we_i),
    .reg_re_i   (reg_re_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_re_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bus_rd(a, d);
    chk(req, {16'h0, d}, {16'h0, exp});
  endtask

  task automatic drive_level(input logic lvl, input int n);
    rx_i = lvl ^ inv_b;
    repeat (n * div_b) @(negedge clk_i);
  endtask

  task automatic send_sym(input int h, input int l, input string tag);
    exp_q.push_back({16'(h), 16'(h + l)});
    tag_q.push_back(tag);
    drive_level(1'b1, h);
    drive_level(1'b0, l);
  endtask

  task automatic send_last(input int h, input string tag);
    exp_q.push_back({16'(h), 16'hFFFF});
    tag_q.push_back(tag);
    drive_level(1'b1, h);
    drive_level(1'b0, 70);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL %s: actual %0d entries pending expected 0", req, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
    mon_on = 1'b0;
    repeat (20) @(negedge clk_i);
  endtask

  // scoreboard monitor
  initial begin
    logic [15:0] st, p, m;
    logic [31:0] e;
    string t;
    forever begin
      @(negedge clk_i);
      if (mon_on) begin
        bus_rd(4'd7, st);
        if (st[15:8] != 8'd0) begin
          bus_rd(4'd9, p);
          bus_rd(4'd8, m);
          if (exp_q.size() == 0) begin
            chk("R1 unexpected entry", {m, p}, 32'h0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {m, p}, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung run expected completion");
    summary();
  end

  initial begin
    logic [15:0] d;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;

    // R12 reset state
    rd_chk("R12 ctrl", 4'd0, 16'h0000);
    rd_chk("R12 div", 4'd1, 16'h0001);
    rd_chk("R12 limit", 4'd2, 16'h5000);
    rd_chk("R12 ien", 4'd4, 16'h0000);
    rd_chk("R12 istat", 4'd5, 16'h0000);
    rd_chk("R12 rxstat", 4'd7, 16'h0000);
    chk("R12 irq", {31'h0, irq_o}, 32'h0);

    // R1 / R3 basic train, divisor 2
    div_b = 2;
    bus_wr(4'd1, 16'd2);
    bus_wr(4'd2, 16'd60);
    bus_wr(4'd3, 16'd0);
    bus_wr(4'd4, 16'h0002);
    bus_wr(4'd0, 16'h0001);
    mon_on = 1'b1;
    drive_level(1'b0, 5);
    send_sym(5, 7, "R1 sym a");
    send_sym(3, 12, "R1 sym b");
    send_sym(10, 4, "R1 sym c");
    send_last(6, "R3 end of train");
    drain("R1 drain");
    chk("R6 irq on last", {31'h0, irq_o}, 32'h1);
    rd_chk("R6 istat after train", 4'd5, 16'h0003);
    bus_wr(4'd6, 16'h0002);
    rd_chk("R6 istat after clear", 4'd5, 16'h0001);
    chk("R6 irq after clear", {31'h0, irq_o}, 32'h0);
    bus_wr(4'd6, 16'h000F);

    // R2 divisor 5
    div_b = 5;
    bus_wr(4'd1, 16'd5);
    mon_on = 1'b1;
    send_sym(4, 9, "R2 sym a");
    send_sym(7, 2, "R2 sym b");
    send_last(2, "R2 end");
    drain("R2 drain");

    // R4 inverted pin
    div_b = 2;
    bus_wr(4'd1, 16'd2);
    bus_wr(4'd0, 16'h0000);
    inv_b = 1'b1;
    rx_i = 1'b1;
    bus_wr(4'd0, 16'h0003);
    mon_on = 1'b1;
    send_sym(8, 5, "R4 sym");
    send_last(3, "R4 end");
    drain("R4 drain");
    bus_wr(4'd0, 16'h0000);
    inv_b = 1'b0;
    rx_i = 1'b0;
    bus_wr(4'd0, 16'h0001);

    // R5 glitch filter width 3
    bus_wr(4'd3, 16'd3);
    mon_on = 1'b1;
    exp_q.push_back({16'd6, 16'd17}); tag_q.push_back("R5 high glitch in space");
    drive_level(1'b1, 6); drive_level(1'b0, 4); drive_level(1'b1, 2); drive_level(1'b0, 5);
    exp_q.push_back({16'd8, 16'd14}); tag_q.push_back("R5 low dip in mark");
    drive_level(1'b1, 4); drive_level(1'b0, 1); drive_level(1'b1, 3); drive_level(1'b0, 6);
    send_last(5, "R5 end");
    drain("R5 drain");
    bus_wr(4'd3, 16'd0);

    // R9 / R7 / R8 overrun
    bus_wr(4'd6, 16'h000F);
    for (int k = 0; k < 9; k++) begin
      drive_level(1'b1, k + 2);
      drive_level(1'b0, 4);
    end
    drive_level(1'b1, 3);
    drive_level(1'b0, 70);
    rd_chk("R7 rxstat full+overrun", 4'd7, 16'h0804);
    rd_chk("R9 istat overrun", 4'd5, 16'h000D);
    bus_wr(4'd4, 16'h0000);
    chk("R6 irq masked", {31'h0, irq_o}, 32'h0);
    for (int k = 0; k < 8; k++) begin
      logic [15:0] p, m;
      bus_rd(4'd9, p);
      bus_rd(4'd8, m);
      chk("R8/R9 kept order", {m, p}, {16'(k + 2), 16'(k + 6)});
    end
    rd_chk("R7 rxstat drained", 4'd7, 16'h0004);
    bus_wr(4'd6, 16'h0004);
    rd_chk("R6 overrun clear", 4'd5, 16'h0009);
    rd_chk("R7 rxstat clear", 4'd7, 16'h0000);
    rd_chk("R8 empty pop", 4'd9, 16'h0000);
    rd_chk("R8 empty pop no effect", 4'd7, 16'h0000);
    bus_wr(4'd6, 16'h000F);
    rd_chk("R6 clear all", 4'd5, 16'h0000);

    // R11 disable flushes and resets timing
    drive_level(1'b1, 4); drive_level(1'b0, 4);
    drive_level(1'b1, 5);
    rd_chk("R11 one entry", 4'd7, 16'h0100);
    rd_chk("R11 istat before", 4'd5, 16'h0001);
    bus_wr(4'd0, 16'h0000);
    rd_chk("R11 rxstat flushed", 4'd7, 16'h0000);
    rd_chk("R11 istat cleared", 4'd5, 16'h0000);
    rx_i = 1'b0;
    repeat (6) @(negedge clk_i);
    bus_wr(4'd0, 16'h0001);
    mon_on = 1'b1;
    send_sym(3, 4, "R11 fresh sym");
    send_last(2, "R11 fresh end");
    drain("R11 drain");

    // R10 saturation
    div_b = 1;
    bus_wr(4'd1, 16'd1);
    bus_wr(4'd2, 16'hFFFF);
    mon_on = 1'b1;
    exp_q.push_back(32'hFFFF_FFFF); tag_q.push_back("R10 saturated mark");
    drive_level(1'b1, 70000);
    drive_level(1'b0, 10);
    drain("R10 drain");
    bus_rd(4'd7, d);
    chk("R10 single entry", {16'h0, d}, 32'h0);

    summary();
  end
endmodule